// File: doc/BRIEF.md
# Eight-Bit ALU with Condition Flags

This block is a single-cycle arithmetic-logic unit for an eight-bit datapath. It takes two operands, `op_b` and `op_c`, and a three-bit function code. A one-hot decoder expands the code and selects one unit: a ripple adder, an incrementer, a row of identical one-bit logic cells, or a circular left rotator. Only the selected unit's value reaches the result bus.

The result bus is driven only while `drive_en` is high and reads zero otherwise. Zero and sign are taken from that gated bus, so a disabled ALU reports zero=1 and sign=0. Carry comes from the selected arithmetic unit and does not depend on the enable.

A small condition-code register captures the three flags on a load strobe, so that later branch logic can test them.

Top module: `cc_alu`

## Requirements
- R1: Function code 0 (binary 000) gives result = (op_b + op_c) mod 256. carry_o is the carry out of bit 7, with a carry-in of 0. The carry is reported whether or not drive_en is high.
- R2: Function code 1 (001) gives result = op_b + 1 mod 256. carry_o is 1 only when op_b is 8'hFF.
- R3: Function codes 2, 3 and 4 (010, 011, 100) give the bitwise AND, OR and XOR of op_b and op_c, and carry_o is 0.
- R4: Function code 5 (101) gives the bitwise inverse of op_b, and carry_o is 0.
- R5: Function code 6 (110) rotates op_b left by one place. op_b bit 7 lands in result bit 0, and each other bit n lands in bit n+1. carry_o is 0.
- R6: Function code 7 (111) gives a result of 0 and a carry_o of 0.
- R7: While drive_en is low, result is 0 for every function code and operand.
- R8: zero_o is 1 exactly when all eight bits of the result bus are 0. This includes the case where drive_en is low.
- R9: sign_o equals bit 7 of the result bus.
- R10: On a rising clock edge with rst high, cc_carry, cc_zero and cc_sign clear to 0. On an edge with ld_flags high, they take the values of carry_o, zero_o and sign_o. On any other edge they hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the condition-code register |
| rst | input | 1 | Synchronous active-high reset of the condition-code register |
| op_b | input | W | First operand |
| op_c | input | W | Second operand |
| func | input | 3 | Function code |
| drive_en | input | 1 | Gates the selected value onto the result bus |
| ld_flags | input | 1 | Captures the three flags at the next rising edge |
| result | output | W | Result bus (zero when not enabled) |
| carry_o | output | 1 | Combinational carry flag |
| zero_o | output | 1 | Combinational zero flag |
| sign_o | output | 1 | Combinational sign flag |
| cc_carry | output | 1 | Registered carry flag |
| cc_zero | output | 1 | Registered zero flag |
| cc_sign | output | 1 | Registered sign flag |

## Verification
The bench builds the block with its default width of eight bits. At that width every one of the 65,536 operand pairs for addition can be swept, so the carry chain is checked across all of its propagate patterns. The wrap points are covered directly: 8'hFF for the incrementer and bit 7 for the rotator. Each remaining function is driven with operand patterns that expose a bit moved to the wrong place. The flag register is checked for capture, hold and reset.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_INC  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_NOT  = 3'd5,
    FN_SHL  = 3'd6,
    FN_NONE = 3'd7
  } alu_fn_e;

  localparam int FN_BITS  = 3;
  localparam int FN_COUNT = 1 << FN_BITS;
endpackage

// File: rtl/cc_fn_decode.sv
module cc_fn_decode #(
  parameter int N = 3
) (
  input  logic [N-1:0]      code,
  output logic [(1<<N)-1:0] sel
);
  localparam int OUTS = 1 << N;

  for (genvar k = 0; k < OUTS; k++) begin : g_line
    assign sel[k] = (code == k[N-1:0]);
  end
endmodule

// File: rtl/cc_logic_cell.sv
module cc_logic_cell (
  input  logic b,
  input  logic c,
  output logic and_o,
  output logic or_o,
  output logic xor_o,
  output logic not_o
);
  assign and_o = b & c;
  assign or_o  = b | c;
  assign xor_o = b ^ c;
  assign not_o = ~b;
endmodule

// File: rtl/cc_ripple_add.sv
module cc_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign cout = cy[W];
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       op_b,
  input  logic [W-1:0]       op_c,
  input  logic [FN_BITS-1:0] func,
  input  logic               drive_en,
  input  logic               ld_flags,
  output logic [W-1:0]       result,
  output logic               carry_o,
  output logic               zero_o,
  output logic               sign_o,
  output logic               cc_carry,
  output logic               cc_zero,
  output logic               cc_sign
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [FN_COUNT-1:0] sel;
  logic [W-1:0]        add_sum, inc_sum;
  logic                add_cy, inc_cy;
  logic [W-1:0]        and_v, or_v, xor_v, not_v, shl_v;
  logic [W-1:0]        unit_v [FN_COUNT];
  logic [W-1:0]        bus_v;

  cc_fn_decode #(.N(FN_BITS)) u_dec (.code(func), .sel(sel));

  cc_ripple_add #(.W(W)) u_add (.a(op_b), .b(op_c), .sum(add_sum), .cout(add_cy));
  cc_ripple_add #(.W(W)) u_inc (.a(op_b), .b(ONE),  .sum(inc_sum), .cout(inc_cy));

  for (genvar i = 0; i < W; i++) begin : g_cell
    cc_logic_cell u_cell (
      .b(op_b[i]), .c(op_c[i]),
      .and_o(and_v[i]), .or_o(or_v[i]), .xor_o(xor_v[i]), .not_o(not_v[i])
    );
  end

  assign shl_v = {op_b[W-2:0], op_b[W-1]};

  always_comb begin
    unit_v[FN_ADD]  = add_sum;
    unit_v[FN_INC]  = inc_sum;
    unit_v[FN_AND]  = and_v;
    unit_v[FN_OR]   = or_v;
    unit_v[FN_XOR]  = xor_v;
    unit_v[FN_NOT]  = not_v;
    unit_v[FN_SHL]  = shl_v;
    unit_v[FN_NONE] = '0;
  end

  always_comb begin
    bus_v = '0;
    for (int k = 0; k < FN_COUNT; k++) begin
      bus_v = bus_v | ({W{sel[k]}} & unit_v[k]);
    end
  end

  assign result  = drive_en ? bus_v : '0;
  assign carry_o = (sel[FN_ADD] & add_cy) | (sel[FN_INC] & inc_cy);
  assign zero_o  = ~|result;
  assign sign_o  = result[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_carry <= 1'b0;
      cc_zero  <= 1'b0;
      cc_sign  <= 1'b0;
    end else if (ld_flags) begin
      cc_carry <= carry_o;
      cc_zero  <= zero_o;
      cc_sign  <= sign_o;
    end
  end

  // R1: the ripple chain agrees with a plain sum
  p_add_r1: assert property (@(posedge clk) disable iff (rst)
    (func == FN_ADD) |-> ({add_cy, add_sum} == ({1'b0, op_b} + {1'b0, op_c})));

  // R2: the incrementer agrees with a plain sum
  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (func == FN_INC) |-> ({inc_cy, inc_sum} == ({1'b0, op_b} + {1'b0, ONE})));

  // R7: a disabled bus shows zero and positive
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (zero_o && !sign_o && result == '0));

  // R10: flags hold without a strobe
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ld_flags) |=> $stable({cc_carry, cc_zero, cc_sign}));

  // R10: flags capture on a strobe
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    (!rst && ld_flags) |=> ({cc_carry, cc_zero, cc_sign} ==
                            $past({carry_o, zero_o, sign_o})));
endmodule

// File: tb/sim_cc_alu.sv
module sim_cc_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_b = '0, op_c = '0;
  logic [2:0] func = '0;
  logic       drive_en = 1'b0, ld_flags = 1'b0;
  logic [7:0] result;
  logic       carry_o, zero_o, sign_o, cc_carry, cc_zero, cc_sign;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_alu #(.W(8)) u0 (
    .clk(clk), .rst(rst), .op_b(op_b), .op_c(op_c), .func(func),
    .drive_en(drive_en), .ld_flags(ld_flags), .result(result),
    .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o),
    .cc_carry(cc_carry), .cc_zero(cc_zero), .cc_sign(cc_sign)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {carry, result}
  function automatic logic [8:0] model(input logic [7:0] b, c, input logic [2:0] f);
    case (f)
      3'd0: return {1'b0, b} + {1'b0, c};
      3'd1: return {1'b0, b} + 9'd1;
      3'd2: return {1'b0, b & c};
      3'd3: return {1'b0, b | c};
      3'd4: return {1'b0, b ^ c};
      3'd5: return {1'b0, ~b};
      3'd6: return {1'b0, b[6:0], b[7]};
      default: return 9'd0;
    endcase
  endfunction

  task automatic apply(input logic [7:0] b, c, input logic [2:0] f, input logic en);
    op_b = b; op_c = c; func = f; drive_en = en;
    #1;
  endtask

  task automatic op_check(input string req, input logic [7:0] b, c, input logic [2:0] f);
    logic [8:0] m;
    apply(b, c, f, 1'b1);
    m = model(b, c, f);
    check(req, {carry_o, result}, m);
    check({req, " zero R8"}, zero_o, (m[7:0] == 8'd0));
    check({req, " sign R9"}, sign_o, m[7]);
  endtask

  task automatic t_reset();
    check("R10 reset carry", cc_carry, 0);
    check("R10 reset zero",  cc_zero,  0);
    check("R10 reset sign",  cc_sign,  0);
  endtask

  task automatic t_add_sweep();
    int bad = 0;
    for (int b = 0; b < 256; b++) begin
      for (int c = 0; c < 256; c++) begin
        apply(b[7:0], c[7:0], 3'd0, 1'b1);
        if ({carry_o, result} != model(b[7:0], c[7:0], 3'd0)) bad++;
      end
    end
    check("R1 exhaustive add mismatches", bad, 0);
    op_check("R1 add FF+01", 8'hFF, 8'h01, 3'd0);
    op_check("R1 add 7F+01", 8'h7F, 8'h01, 3'd0);
  endtask

  task automatic t_inc();
    op_check("R2 inc 00", 8'h00, 8'h55, 3'd1);
    op_check("R2 inc 7F", 8'h7F, 8'h00, 3'd1);
    op_check("R2 inc FF", 8'hFF, 8'hFF, 3'd1);
  endtask

  task automatic t_logic();
    op_check("R3 and", 8'hF0, 8'h3C, 3'd2);
    op_check("R3 and disjoint", 8'hAA, 8'h55, 3'd2);
    op_check("R3 or",  8'hA0, 8'h05, 3'd3);
    op_check("R3 xor", 8'hFF, 8'h0F, 3'd4);
    op_check("R3 xor equal", 8'h5A, 8'h5A, 3'd4);
    op_check("R4 not", 8'h0F, 8'hFF, 3'd5);
    op_check("R4 not FF", 8'hFF, 8'h00, 3'd5);
  endtask

  task automatic t_shl();
    op_check("R5 shl 80", 8'h80, 8'h00, 3'd6);
    op_check("R5 shl 81", 8'h81, 8'h00, 3'd6);
    op_check("R5 shl 40", 8'h40, 8'hFF, 3'd6);
    op_check("R5 shl 96", 8'h96, 8'h00, 3'd6);
  endtask

  task automatic t_none();
    op_check("R6 code 7", 8'hFF, 8'hFF, 3'd7);
  endtask

  task automatic t_disable();
    for (int f = 0; f < 8; f++) begin
      apply(8'hC3, 8'h81, f[2:0], 1'b0);
      check("R7 disabled result", result, 0);
      check("R8 disabled zero", zero_o, 1);
      check("R9 disabled sign", sign_o, 0);
    end
    apply(8'hFF, 8'h01, 3'd0, 1'b0);
    check("R1 carry independent of enable", carry_o, 1);
  endtask

  task automatic t_flags();
    @(negedge clk);
    apply(8'hFF, 8'h81, 3'd0, 1'b1);        // 0x80 carry=1 sign=1 zero=0
    ld_flags = 1'b1;
    @(negedge clk);
    ld_flags = 1'b0;
    check("R10 load carry", cc_carry, 1);
    check("R10 load zero",  cc_zero,  0);
    check("R10 load sign",  cc_sign,  1);
    apply(8'h00, 8'h00, 3'd2, 1'b1);        // zero=1 carry=0 sign=0
    @(negedge clk);
    check("R10 hold carry", cc_carry, 1);
    check("R10 hold zero",  cc_zero,  0);
    check("R10 hold sign",  cc_sign,  1);
    ld_flags = 1'b1;
    @(negedge clk);
    ld_flags = 1'b0;
    check("R10 reload zero",  cc_zero,  1);
    check("R10 reload carry", cc_carry, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 sync reset zero", cc_zero, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_add_sweep();
    t_inc();
    t_logic();
    t_shl();
    t_none();
    t_disable();
    t_flags();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule